// File: doc/BRIEF.md
# Reset Bus Microcycle Sequencer

This block drives the 16-bit bus of a microcoded processor from reset until the first instruction word is ready. After reset it runs a fixed script of bus steps. First come idle microcycles. Then come six word reads, each split into an address step and a data step. The first four reads load the supervisor stack pointer and the program counter, high word first. The last two prefetch the first instruction words into a two-entry queue.

One clock of `clk` is one bus half-cycle. The data step of each read stretches while the transfer acknowledge is low, unless the acknowledge is configured as implicit. When the script ends, the block raises a done flag and the bus goes quiet. The instruction decoder then reads the loaded stack pointer, the program counter and both queue words from the outputs.

Top module: `reset_bus_seq`

## Requirements
- R1: While `rst_n` is low (asserted asynchronously), `seq_done`, `bus_rd`, `strobe_hi`, `strobe_lo`, `fetch_q0`, `fetch_q1`, `stack_ptr` and `prog_ctr` are all 0, and the internal read pointer is cleared so the next sequence reads from address 0.
- R2: Sequencing starts two clocks after `rst_n` is released (internal synchronizer). It begins with twelve idle microcycles of four clocks each, during which `bus_rd` and both strobes stay low. The first `bus_rd` is therefore seen 50 clocks after release.
- R3: The reads come in this order: stack pointer high word at address 0, stack pointer low word at 2, program counter high word at 4, program counter low word at 6, then two prefetches at the loaded program counter and at that value plus 2.
- R4: Each read is one address clock, with `bus_rd` high and both strobes low, followed by a data step of three clocks with `bus_rd` and both strobes high. `bus_addr` is unchanged across the two steps.
- R5: `bus_fc` is 3'b110 (supervisor program space) whenever `bus_rd` is high, and 3'b000 otherwise.
- R6: With `ack_implicit` low, every clock of a data step in which `xfer_ack` is low is a wait state. The step holds and `bus_addr` does not change. The whole sequence takes 74 clocks plus the number of wait states, counted from release to the first clock with `seq_done` high.
- R7: With `ack_implicit` high, `xfer_ack` has no effect. The sequence takes exactly 74 clocks even with `xfer_ack` held low.
- R8: At the end, `fetch_q0` holds the word at the vector program counter and `fetch_q1` holds the word at that address plus 2. The address step of each prefetch moves entry 1 into entry 0. `prog_ctr` ends at the vector value plus 4.
- R9: `stack_ptr` equals {word at address 0, word at address 2}.
- R10: `seq_done` rises after the last data step and then stays high with no further bus activity until reset.
- R11: A reset asserted anywhere in the sequence, including mid-read, clears the queue and the done flag at once. After release, the whole sequence restarts from the first idle microcycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus half-cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_implicit | input | 1 | 1: treat transfer acknowledge as always present |
| xfer_ack | input | 1 | Transfer acknowledge from memory, active high |
| rd_data | input | 16 | Read data word |
| bus_addr | output | ADDR_W | Byte address of the current read |
| bus_fc | output | 3 | Function code (address space) |
| bus_rd | output | 1 | Read cycle in progress |
| strobe_hi | output | 1 | Upper byte data strobe |
| strobe_lo | output | 1 | Lower byte data strobe |
| stack_ptr | output | 32 | Loaded supervisor stack pointer |
| prog_ctr | output | 32 | Program counter |
| fetch_q0 | output | 16 | Prefetch queue entry 0 (oldest) |
| fetch_q1 | output | 16 | Prefetch queue entry 1 |
| seq_done | output | 1 | Reset program finished |

## Verification
The hardest case is a wait state that lands on the last clock of a data step, just as the captured word is about to update a register or the queue. A one-clock error in the hold logic would then capture early or skip the increment. The memory model draws a fresh random wait budget before every data step, so waits fall at the start, middle and end of steps, on all six reads. The exact total cycle count catches any lost or extra clock. A second hard case is a reset that arrives while a read is half done. The bench aborts a run during the read phase and after completion, and then checks that the next run still starts from address 0.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_ADDR,
    STEP_DATA,
    STEP_END
  } step_kind_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SP_HI,
    TGT_SP_LO,
    TGT_PC_HI,
    TGT_PC_LO,
    TGT_FETCH
  } tgt_e;

  localparam logic [2:0] FC_SUP_PROG = 3'b110;
  localparam logic [2:0] FC_QUIET    = 3'b000;
  localparam int         READ_COUNT  = 6;
endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/rbs_step_decode.sv
module rbs_step_decode
  import rbs_pkg::*;
#(
  parameter int IDLE_N  = 12,
  parameter int IDX_W   = 5,
  parameter int HC_W    = 3,
  parameter int IDLE_HC = 4,
  parameter int ADDR_HC = 1,
  parameter int DATA_HC = 3
) (
  input  logic [IDX_W-1:0] step_idx,
  output step_kind_e       kind,
  output tgt_e             tgt,
  output logic [HC_W-1:0]  last_hc
);
  always_comb begin
    int off;
    int rnum;
    off     = int'(step_idx) - IDLE_N;
    rnum    = off >>> 1;
    kind    = STEP_END;
    tgt     = TGT_NONE;
    last_hc = '0;
    if (off < 0) begin
      kind    = STEP_IDLE;
      last_hc = HC_W'(IDLE_HC - 1);
    end else if (off < 2 * READ_COUNT) begin
      kind    = off[0] ? STEP_DATA : STEP_ADDR;
      last_hc = off[0] ? HC_W'(DATA_HC - 1) : HC_W'(ADDR_HC - 1);
      case (rnum)
        0:       tgt = TGT_SP_HI;
        1:       tgt = TGT_SP_LO;
        2:       tgt = TGT_PC_HI;
        3:       tgt = TGT_PC_LO;
        default: tgt = TGT_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/reset_bus_seq.sv
module reset_bus_seq
  import rbs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int IDLE_N  = 12,
  parameter int IDLE_HC = 4,
  parameter int ADDR_HC = 1,
  parameter int DATA_HC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_implicit,
  input  logic              xfer_ack,
  input  logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_fc,
  output logic              bus_rd,
  output logic              strobe_hi,
  output logic              strobe_lo,
  output logic [31:0]       stack_ptr,
  output logic [31:0]       prog_ctr,
  output logic [15:0]       fetch_q0,
  output logic [15:0]       fetch_q1,
  output logic              seq_done
);
  localparam int N_STEPS = IDLE_N + 2 * READ_COUNT;
  localparam int IDX_W   = $clog2(N_STEPS + 1);
  localparam int HC_W    = $clog2(IDLE_HC + DATA_HC + ADDR_HC + 1);

  logic              rst_n_sync;
  logic [IDX_W-1:0]  step_q, step_d;
  logic [HC_W-1:0]   hc_q, hc_d, last_hc;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic [31:0]       sp_q, sp_d, pc_q, pc_d;
  logic [15:0]       q0_q, q1_q;
  step_kind_e        kind;
  tgt_e              tgt;
  logic              hold, run, fin;
  logic              step_en, hc_en, ea_en, sp_en, pc_en, q0_en, q1_en;

  rbs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rbs_step_decode #(
    .IDLE_N (IDLE_N), .IDX_W (IDX_W), .HC_W (HC_W),
    .IDLE_HC(IDLE_HC), .ADDR_HC(ADDR_HC), .DATA_HC(DATA_HC)
  ) u_decode (
    .step_idx (step_q),
    .kind     (kind),
    .tgt      (tgt),
    .last_hc  (last_hc)
  );

  // Next-state and enables
  always_comb begin
    hold    = (kind == STEP_DATA) && !(ack_implicit || xfer_ack);
    run     = (kind != STEP_END) && !hold;
    fin     = run && (hc_q == last_hc);
    step_en = fin;
    step_d  = step_q + IDX_W'(1);
    hc_en   = run;
    hc_d    = fin ? '0 : hc_q + HC_W'(1);
    ea_en   = fin && (kind == STEP_DATA) && (tgt != TGT_FETCH);
    ea_d    = ea_q + ADDR_W'(2);
    sp_en   = fin && (kind == STEP_DATA) && ((tgt == TGT_SP_HI) || (tgt == TGT_SP_LO));
    sp_d    = (tgt == TGT_SP_HI) ? {rd_data, sp_q[15:0]} : {sp_q[31:16], rd_data};
    pc_en   = fin && (kind == STEP_DATA) &&
              ((tgt == TGT_PC_HI) || (tgt == TGT_PC_LO) || (tgt == TGT_FETCH));
    case (tgt)
      TGT_PC_HI: pc_d = {rd_data, pc_q[15:0]};
      TGT_PC_LO: pc_d = {pc_q[31:16], rd_data};
      default:   pc_d = pc_q + 32'd2;
    endcase
    q0_en   = fin && (kind == STEP_ADDR) && (tgt == TGT_FETCH);
    q1_en   = fin && (kind == STEP_DATA) && (tgt == TGT_FETCH);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      step_q <= '0;
      hc_q   <= '0;
    end else begin
      if (step_en) step_q <= step_d;
      if (hc_en)   hc_q   <= hc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ea_q <= '0;
      sp_q <= '0;
      pc_q <= '0;
      q0_q <= '0;
      q1_q <= '0;
    end else begin
      if (ea_en) ea_q <= ea_d;
      if (sp_en) sp_q <= sp_d;
      if (pc_en) pc_q <= pc_d;
      if (q0_en) q0_q <= q1_q;
      if (q1_en) q1_q <= rd_data;
    end
  end

  // Outputs
  always_comb begin
    bus_rd    = (kind == STEP_ADDR) || (kind == STEP_DATA);
    strobe_hi = (kind == STEP_DATA);
    strobe_lo = (kind == STEP_DATA);
    bus_addr  = (tgt == TGT_FETCH) ? pc_q[ADDR_W-1:0] : ea_q;
    bus_fc    = bus_rd ? FC_SUP_PROG : FC_QUIET;
    seq_done  = (kind == STEP_END);
  end

  assign stack_ptr = sp_q;
  assign prog_ctr  = pc_q;
  assign fetch_q0  = q0_q;
  assign fetch_q1  = q1_q;
endmodule

// File: rtl/reset_bus_seq_chk.sv
module reset_bus_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_implicit,
  input logic              xfer_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_fc,
  input logic              bus_rd,
  input logic              strobe_hi,
  input logic              strobe_lo,
  input logic              seq_done
);
  // R4
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !strobe_hi && !strobe_lo) |=> (bus_rd && strobe_hi && strobe_lo && $stable(bus_addr)));

  // R4
  strobe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_hi || strobe_lo) |-> (bus_rd && strobe_hi && strobe_lo));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_hi && !ack_implicit && !xfer_ack) |=> (strobe_hi && $stable(bus_addr)));

  // R5
  fc_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_fc == 3'b110));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (seq_done && !bus_rd && !strobe_hi));
endmodule

bind reset_bus_seq reset_bus_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_implicit (ack_implicit),
  .xfer_ack     (xfer_ack),
  .bus_addr     (bus_addr),
  .bus_fc       (bus_fc),
  .bus_rd       (bus_rd),
  .strobe_hi    (strobe_hi),
  .strobe_lo    (strobe_lo),
  .seq_done     (seq_done)
);

// File: tb/reset_bus_seq_tb_top.sv
`timescale 1ns/1ps
module reset_bus_seq_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ack_implicit;
  logic          xfer_ack;
  logic [15:0]   rd_data;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_fc;
  logic          bus_rd, strobe_hi, strobe_lo, seq_done;
  logic [31:0]   stack_ptr, prog_ctr;
  logic [15:0]   fetch_q0, fetch_q1;

  always #10 clk = ~clk;

  reset_bus_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ack_implicit(ack_implicit), .xfer_ack(xfer_ack),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rd(bus_rd),
    .strobe_hi(strobe_hi), .strobe_lo(strobe_lo), .stack_ptr(stack_ptr),
    .prog_ctr(prog_ctr), .fetch_q0(fetch_q0), .fetch_q1(fetch_q1), .seq_done(seq_done)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] vec_w [4];
  logic [15:0] key;
  bit force_low;
  int max_wait;
  int budget;
  int waits;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    if (a < 8) return vec_w[a[2:1]];
    return (a[15:0] * 16'h9e37) ^ a[23:8] ^ key;
  endfunction

  // Memory model: data and acknowledge with random wait budget per data step
  always @(negedge clk) begin
    rd_data <= mem_word(bus_addr);
    if (force_low) xfer_ack <= 1'b0;
    else if (strobe_hi && budget > 0) begin
      xfer_ack <= 1'b0;
      budget = budget - 1;
      waits  = waits + 1;
    end else begin
      xfer_ack <= 1'b1;
      if (!strobe_hi) budget = (max_wait == 0) ? 0 : int'($urandom % (max_wait + 1));
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reset_state_checks();
    chk("R1", "done in reset", seq_done, 0);
    chk("R1", "rd/strobes in reset", {bus_rd, strobe_hi, strobe_lo}, 0);
    chk("R1", "queue in reset", {fetch_q0, fetch_q1}, 0);
    chk("R1", "sp/pc in reset", {stack_ptr, prog_ctr}, 0);
  endtask

  task automatic run_trial(input bit impl, input bit flow, input int mw,
                           input logic [31:0] sp, input logic [31:0] pcv);
    int cnt, first, n_addr, viol, fcv, idlev;
    bit prev_ap, ap;
    logic [AW-1:0] prev_a;
    logic [AW-1:0] addrs [6];
    logic [AW-1:0] exp_a [6];
    rst_n = 1'b0;
    ack_implicit = impl; force_low = flow; max_wait = mw;
    vec_w[0] = sp[31:16]; vec_w[1] = sp[15:0];
    vec_w[2] = pcv[31:16]; vec_w[3] = pcv[15:0];
    key = 16'($urandom);
    repeat (3) @(negedge clk);
    budget = 0; waits = 0;
    reset_state_checks();
    rst_n = 1'b1;
    cnt = 0; first = -1; n_addr = 0; viol = 0; fcv = 0; idlev = 0; prev_ap = 0; prev_a = '0;
    while (!seq_done && cnt < 600) begin
      if (bus_rd && first < 0) first = cnt;
      if (first < 0 && (strobe_hi || strobe_lo)) idlev++;
      if (bus_rd ? (bus_fc != 3'b110) : (bus_fc != 3'b000)) fcv++;
      if (prev_ap && !(strobe_hi && strobe_lo && bus_addr == prev_a)) viol++;
      ap = bus_rd && !strobe_hi && !strobe_lo;
      if (ap) begin
        if (n_addr < 6) addrs[n_addr] = bus_addr;
        n_addr++;
      end
      prev_ap = ap; prev_a = bus_addr;
      cnt++;
      @(negedge clk);
    end
    chk(impl ? "R7" : "R6", "total cycles", cnt, 74 + (impl ? 0 : waits));
    chk("R2", "first read cycle", first, 50);
    chk("R2", "strobes during idle", idlev, 0);
    chk("R3", "read count", n_addr, 6);
    exp_a[0] = 0; exp_a[1] = 2; exp_a[2] = 4; exp_a[3] = 6;
    exp_a[4] = pcv[AW-1:0]; exp_a[5] = pcv[AW-1:0] + AW'(2);
    for (int i = 0; i < 6; i++) chk("R3", $sformatf("read %0d address", i), addrs[i], exp_a[i]);
    chk("R4", "address/data step shape", viol, 0);
    chk("R5", "function code", fcv, 0);
    chk("R9", "stack pointer", stack_ptr, sp);
    chk("R8", "final pc", prog_ctr, pcv + 32'd4);
    chk("R8", "queue entry 0", fetch_q0, mem_word(pcv[AW-1:0]));
    chk("R8", "queue entry 1", fetch_q1, mem_word(pcv[AW-1:0] + AW'(2)));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", "done sticky, bus quiet", {seq_done, bus_rd, strobe_hi}, 3'b100);
    end
  endtask

  function automatic logic [31:0] rand_pc();
    return {16'(($urandom & 32'hff) + 1), 16'(($urandom & 32'hfffe) | 32'h0100)};
  endfunction

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; ack_implicit = 1'b0; xfer_ack = 1'b1; force_low = 1'b0;
    max_wait = 0; budget = 0; waits = 0; key = '0;
    for (int i = 0; i < 4; i++) vec_w[i] = '0;
    // directed: no waits
    run_trial(1'b0, 1'b0, 0, 32'h00ff_fffe, 32'h0000_0400);
    // directed: implicit acknowledge with acknowledge held low
    run_trial(1'b1, 1'b1, 0, $urandom, rand_pc());
    // random wait states
    for (int t = 0; t < 6; t++) run_trial(1'b0, 1'b0, 1 + t % 4, $urandom, rand_pc());
    // R11: asynchronous reset mid-cycle after completion clears state
    @(negedge clk); #5 rst_n = 1'b0; #1;
    chk("R11", "queue cleared async", {fetch_q0, fetch_q1}, 0);
    chk("R11", "done cleared async", seq_done, 0);
    // R11: abort during the read phase, then a fresh run must restart
    @(negedge clk); rst_n = 1'b1; max_wait = 2;
    repeat (62) @(negedge clk);
    chk("R11", "aborted run mid-read", bus_rd, 1);
    #3 rst_n = 1'b0; #1;
    chk("R11", "reset mid-read stops bus", {bus_rd, strobe_hi}, 0);
    run_trial(1'b0, 1'b0, 3, $urandom, rand_pc());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule